// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Selector

This block selects which segment of a large external ROM or flash appears in an 8K cartridge window. The host CPU picks a bank by writing to the window. The write's data is never seen. The bank number comes from the address of the write: the offset within the window is shifted right by one, so the byte-lane bit is dropped. The latched number drives the high address lines of the memory device.

The block is built as one of four variants, chosen by two parameters. The window mode selects whether the whole 8K is remapped, or only the upper 4K while the lower 4K stays on the first segment. The segment order selects whether bank numbers count up through the device or down from its top. Reset always returns the latch to bank 0, so the power-on mapping is defined.

Top module: `cart_bank_sel`

## Requirements
- R1: A clock edge that sees both `cart_sel` and `wr_en` high loads the latch with bank number `win_addr[BANK_BITS:1]`. The block has no data input.
- R2: Offset bit 0 plays no part in the bank number, so an odd offset selects the same bank as the even offset just below it.
- R3: Even offsets map to consecutive banks: offset 2k selects bank k (offset 0x0002 gives bank 1, offset 0x01FE gives bank 255 with 8 bank bits).
- R4: Offset bits above bit BANK_BITS are dropped, so bank numbers wrap. With 8 bank bits, offset 0x0200 selects bank 0.
- R5: An edge where `cart_sel` or `wr_en` is low leaves the latched bank unchanged.
- R6: While `rst_n` is low, the latched bank is 0.
- R7: In full-window mode, `rom_hi` gives the segment of the latched bank for every offset, whatever the value of `win_addr[12]`.
- R8: In half-window mode, `rom_hi` gives the segment of bank 0 when `win_addr[12]` is 0, and the segment of the latched bank when it is 1.
- R9: In downward order, the segment of bank b is (2^BANK_BITS − 1) − b. This includes the fixed lower half, which then shows all ones. In upward order, the segment equals b.
- R10: A new bank appears on `rom_hi` from the first access after the clock edge that latched it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_addr | input | WIN_AW (13) | Byte offset of the access within the 8K window |
| cart_sel | input | 1 | High when the access falls in cartridge space |
| wr_en | input | 1 | High for a write access |
| rom_hi | output | BANK_BITS (8) | High address bits driven to the ROM or flash |

## Verification
The bench runs all four variants side by side on the same stimulus, so a single access shows whether the offset's top bit and the order setting act independently. Directed writes cover the following cases, each of which exposes a different decode fault:
- odd offsets, which catch a decode that keeps bit 0;
- the highest in-range even offset, which catches a shifted or truncated bank field;
- an offset just past the bank range, which catches a missing wrap;
- writes with only one qualifier high, which catch a latch that ignores `cart_sel` or `wr_en`.

Seeded random traffic then mixes reads and writes across the whole window. Reading both halves after each write separates the fixed lower half from the switched upper half.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int CBS_WIN_AW        = 13;
    localparam int CBS_MAX_BANK_BITS = CBS_WIN_AW - 1;

    typedef enum logic {
        CBS_WIN_FULL = 1'b0,
        CBS_WIN_HALF = 1'b1
    } cbs_win_e;

    typedef enum logic {
        CBS_ORDER_UP   = 1'b0,
        CBS_ORDER_DOWN = 1'b1
    } cbs_order_e;

endpackage

// File: rtl/cbs_decode.sv
module cbs_decode #(
    parameter int WIN_AW    = 13,
    parameter int BANK_BITS = 8
) (
    input  logic [WIN_AW-1:0]    win_addr,
    input  logic                 cart_sel,
    input  logic                 wr_en,
    output logic                 hit,
    output logic [BANK_BITS-1:0] idx
);

    localparam int IDX_LSB = 1;
    localparam int IDX_MSB = BANK_BITS;

    // Byte-lane bit dropped; bits above the bank field dropped (wrap).
    always_comb begin
        hit = cart_sel & wr_en;
        idx = win_addr[IDX_MSB:IDX_LSB];
    end

endmodule

// File: rtl/cbs_latch.sv
module cbs_latch #(
    parameter int BANK_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [BANK_BITS-1:0] idx,
    output logic [BANK_BITS-1:0] bank
);

    typedef struct packed {
        logic [BANK_BITS-1:0] bank;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (hit) begin
            state_d.bank = idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;

    assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (bank == $past(idx)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(bank));

    assert_reset_bank0_R6: assert property (@(posedge clk)
        !rst_n |-> (bank == '0));

endmodule

// File: rtl/cbs_map.sv
module cbs_map
    import cbs_pkg::*;
#(
    parameter int         BANK_BITS = 8,
    parameter cbs_win_e   WIN_MODE  = CBS_WIN_FULL,
    parameter cbs_order_e ORDER     = CBS_ORDER_UP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_BITS-1:0] bank,
    input  logic                 upper,
    output logic [BANK_BITS-1:0] seg
);

    localparam bit IS_HALF = (WIN_MODE == CBS_WIN_HALF);
    localparam bit IS_DOWN = (ORDER == CBS_ORDER_DOWN);
    localparam logic [BANK_BITS-1:0] FIXED_SEG = IS_DOWN ? '1 : '0;

    logic [BANK_BITS-1:0] sel_bank;

    generate
        if (IS_HALF) begin : g_half
            always_comb sel_bank = upper ? bank : '0;
        end else begin : g_full
            always_comb sel_bank = bank;
        end

        if (IS_DOWN) begin : g_down
            always_comb seg = ~sel_bank;
        end else begin : g_up
            always_comb seg = sel_bank;
        end
    endgenerate

    assert_full_no_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_HALF && $stable(bank)) |-> $stable(seg));

    assert_half_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_HALF && !upper) |-> (seg == FIXED_SEG));

    assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_HALF || upper) |-> ((seg ^ bank) == FIXED_SEG));

endmodule

// File: rtl/cart_bank_sel.sv
module cart_bank_sel
    import cbs_pkg::*;
#(
    parameter int         WIN_AW    = CBS_WIN_AW,
    parameter int         BANK_BITS = 8,
    parameter cbs_win_e   WIN_MODE  = CBS_WIN_FULL,
    parameter cbs_order_e ORDER     = CBS_ORDER_UP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIN_AW-1:0]    win_addr,
    input  logic                 cart_sel,
    input  logic                 wr_en,
    output logic [BANK_BITS-1:0] rom_hi
);

    localparam int HALF_BIT = WIN_AW - 1;

    logic                 hit;
    logic [BANK_BITS-1:0] idx;
    logic [BANK_BITS-1:0] bank;

    cbs_decode #(
        .WIN_AW    (WIN_AW),
        .BANK_BITS (BANK_BITS)
    ) u_decode (
        .win_addr (win_addr),
        .cart_sel (cart_sel),
        .wr_en    (wr_en),
        .hit      (hit),
        .idx      (idx)
    );

    cbs_latch #(
        .BANK_BITS (BANK_BITS)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .idx   (idx),
        .bank  (bank)
    );

    cbs_map #(
        .BANK_BITS (BANK_BITS),
        .WIN_MODE  (WIN_MODE),
        .ORDER     (ORDER)
    ) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .bank  (bank),
        .upper (win_addr[HALF_BIT]),
        .seg   (rom_hi)
    );

    // R2: an odd/even write pair lands on the same bank.
    assert_pair_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(hit) && ((win_addr ^ $past(win_addr)) == {{(WIN_AW-1){1'b0}}, 1'b1}))
        |=> (bank == $past(bank)));

endmodule

// File: tb/sim_cart_bank_sel.sv
module sim_cart_bank_sel;
    import cbs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BB         = 8;
    localparam int AW         = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] win_addr;
    logic          cart_sel;
    logic          wr_en;
    logic [BB-1:0] hi0, hi1, hi2, hi3;

    int checks = 0;
    int fails  = 0;
    logic [BB-1:0] model_bank;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_sel #(.BANK_BITS(BB), .WIN_MODE(CBS_WIN_FULL), .ORDER(CBS_ORDER_UP))
        u0 (.clk(clk), .rst_n(rst_n), .win_addr(win_addr), .cart_sel(cart_sel), .wr_en(wr_en), .rom_hi(hi0));
    cart_bank_sel #(.BANK_BITS(BB), .WIN_MODE(CBS_WIN_HALF), .ORDER(CBS_ORDER_UP))
        u1 (.clk(clk), .rst_n(rst_n), .win_addr(win_addr), .cart_sel(cart_sel), .wr_en(wr_en), .rom_hi(hi1));
    cart_bank_sel #(.BANK_BITS(BB), .WIN_MODE(CBS_WIN_FULL), .ORDER(CBS_ORDER_DOWN))
        u2 (.clk(clk), .rst_n(rst_n), .win_addr(win_addr), .cart_sel(cart_sel), .wr_en(wr_en), .rom_hi(hi2));
    cart_bank_sel #(.BANK_BITS(BB), .WIN_MODE(CBS_WIN_HALF), .ORDER(CBS_ORDER_DOWN))
        u3 (.clk(clk), .rst_n(rst_n), .win_addr(win_addr), .cart_sel(cart_sel), .wr_en(wr_en), .rom_hi(hi3));

    function automatic logic [BB-1:0] exp_seg(input logic [BB-1:0] b, input logic [AW-1:0] a,
                                              input bit half, input bit down);
        logic [BB-1:0] x;
        x = (half && !a[AW-1]) ? '0 : b;
        return down ? ~x : x;
    endfunction

    task automatic cmp(input string tag, input string inst, input logic [BB-1:0] act,
                       input logic [BB-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, inst, win_addr, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, "/R7"}, "u0", hi0, exp_seg(model_bank, win_addr, 1'b0, 1'b0));
        cmp({tag, "/R8"}, "u1", hi1, exp_seg(model_bank, win_addr, 1'b1, 1'b0));
        cmp({tag, "/R9"}, "u2", hi2, exp_seg(model_bank, win_addr, 1'b0, 1'b1));
        cmp({tag, "/R9"}, "u3", hi3, exp_seg(model_bank, win_addr, 1'b1, 1'b1));
    endtask

    // Drive at negedge, check the combinational view, then account for the coming edge.
    task automatic step(input logic [AW-1:0] a, input logic w, input logic s, input string tag);
        @(negedge clk);
        win_addr = a;
        wr_en    = w;
        cart_sel = s;
        #1;
        check_all(tag);
        if (w && s && rst_n) model_bank = a[BB:1];
    endtask

    // Read both halves after the latching edge (R10).
    task automatic read_both(input string tag);
        step(13'h0100, 1'b0, 1'b1, tag);
        step(13'h1100, 1'b0, 1'b1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; win_addr = '0; cart_sel = 1'b0; wr_en = 1'b0;
        model_bank = '0;
        step(13'h1002, 1'b1, 1'b1, "R6 reset");
        step(13'h0004, 1'b0, 1'b0, "R6 reset");
        @(negedge clk); rst_n = 1'b1;
        read_both("R6 after reset");

        step(13'h0002, 1'b1, 1'b1, "R1 R3 write 0x0002");
        read_both("R10 R3 bank1");
        step(13'h0007, 1'b1, 1'b1, "R2 odd 0x0007");
        read_both("R2 bank3");
        step(13'h0006, 1'b1, 1'b1, "R2 even 0x0006");
        read_both("R2 even pair");
        step(13'h01FE, 1'b1, 1'b1, "R3 top 0x01FE");
        read_both("R3 bank255");
        step(13'h0010, 1'b1, 1'b0, "R5 no cart_sel");
        read_both("R5 hold no sel");
        step(13'h0012, 1'b0, 1'b1, "R5 read only");
        read_both("R5 hold read");
        step(13'h0200, 1'b1, 1'b1, "R4 wrap 0x0200");
        read_both("R4 bank0");
        step(13'h1E0A, 1'b1, 1'b1, "R4 wrap 0x1E0A");
        read_both("R4 bank5");

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic w, s;
            a = AW'($urandom);
            w = ($urandom % 2) == 0;
            s = ($urandom % 10) < 7;
            step(a, w, s, "R1 R5 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule